// File: doc/BRIEF.md
# Edge-Clocked Slave Counter

This block is an up-counter that a timer uses when its count clock can be swapped. In the internal-clock mode the counter advances on every cycle of the system clock. In the external edge mode it advances once for each qualified edge on the channel-2 input pin. The path from the pin to the counter has four stages. A two-flop resynchronizer comes first. A digital debounce filter follows, and its length is set by a 4-bit code. An edge selector then picks rising or falling edges. Last, a trigger-source multiplexer decides whether the channel-2 edge reaches the counter at all.

Every qualified trigger that reaches the multiplexer output sets a sticky trigger flag. This happens in every counter mode. Software clears the flag with a one-cycle clear pulse, which stands in for writing zero to it. The configuration arrives on plain ports, and the count value leaves on a plain port.

There are two state machines.

The filter machine has two states:
- `FLT_STABLE`: the filtered level matches the input. When the input differs, the machine goes *stable→qualify*, or it updates the level at once if the code is zero.
- `FLT_QUAL`: a change is being timed. *Qualify→stable on bounce* occurs when the input returns to the old level. *Qualify→stable on accept* occurs when enough samples have been seen, and the level then updates.

The counter machine has three states: `CNT_HALT`, `CNT_INTCLK` and `CNT_EXTCLK`. On every clock it moves to the state that matches the current enable and mode inputs:
- *any→halt* when the counter is disabled or the mode code is unsupported.
- *any→internal* when the counter is enabled and the mode is `000`.
- *any→external* when the counter is enabled and the mode is `111`.

Top module: `trig_count_slave`

## Requirements
- R1: After reset the count value is 0 and the trigger flag is 0.
- R2: With enable=1, mode `111`, trigger select `110`, channel direction `01`, filter code 0 and polarity 0, each rising edge of the pin increments the count by exactly 1.
- R3: With polarity 1, falling edges of the pin increment the count and rising edges do not.
- R4: For filter code N>0, a pin pulse held for N or fewer cycles produces no count, and a pulse held for N+1 cycles produces one count. With code 0, a single-cycle pulse counts.
- R5: Suppose the pin reaches a new level before clock edge k. The count and the flag then change on edge k+3+N, where N is the filter code, and not before that edge.
- R6: While enable is 0, the count holds its value in every mode.
- R7: With enable=1 and mode `000`, the count increments by 1 on every clock cycle.
- R8: With any trigger select code other than `110`, pin edges neither change the count nor set the flag.
- R9: With a channel direction other than `01`, pin edges neither change the count nor set the flag.
- R10: Each qualified trigger sets the flag. A clear pulse resets the flag, but a trigger in the same cycle as a clear leaves the flag set.
- R11: In external mode a pin that is held high for many cycles gives only one count, and the count never advances by more than 1 per cycle.
- R12: Mode codes other than `000` and `111` hold the count even while enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| slave_mode | input | 3 | Count source mode: `000` internal clock, `111` external edges, others halt |
| trig_sel | input | 3 | Trigger source select: `110` is filtered channel 2, other codes are tied off |
| ch2_dir | input | 2 | Channel-2 direction: `01` routes the pin to the edge detector |
| filt_code | input | 4 | Debounce length N: a change needs N+1 equal samples, and 0 means unfiltered |
| ch2_pol | input | 1 | Edge polarity: 0 for rising, 1 for falling |
| ch2_pin | input | 1 | Asynchronous channel-2 pin |
| flag_clr | input | 1 | One-cycle clear of the trigger flag |
| cnt_val | output | 16 | Counter value |
| trig_flag | output | 1 | Sticky trigger flag |

## Verification
The checker watches the counter on every cycle:
- In the halt state the count is held.
- In the internal state it steps by exactly one.
- In the external state it steps by at most one, and by exactly one when a trigger arrives.
- A trigger always leaves the flag set, and a clear with no trigger leaves it cleared.
- No trigger appears under a foreign select code.

Some behaviour only the directed scenarios can show, because it depends on what happens at the pin. These are the exact 3+N cycle latency from pin to count, the rejection of pulses one sample too short, and the choice between rising and falling edges. They also include the gating by channel direction and the rule that a level held high counts only once.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    // Counter source states
    typedef enum logic [1:0] {
        CNT_HALT   = 2'd0,
        CNT_INTCLK = 2'd1,
        CNT_EXTCLK = 2'd2
    } cnt_state_t;

    // Debounce filter states
    typedef enum logic {
        FLT_STABLE = 1'b0,
        FLT_QUAL   = 1'b1
    } flt_state_t;

    localparam logic [2:0] MODE_INTERNAL = 3'b000;
    localparam logic [2:0] MODE_EXT_EDGE = 3'b111;
    localparam logic [2:0] TSEL_CH2      = 3'b110;
    localparam logic [1:0] DIR_CH2_IN    = 2'b01;

endpackage

// File: rtl/tcs_in_cond.sv
// Channel-2 input conditioning: resynchronizer, debounce filter, edge select.
module tcs_in_cond
    import tcs_pkg::*;
#(
    parameter int FILT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  logic [FILT_W-1:0] filt_code,
    input  logic              pol,
    output logic              edge_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
        end
    end

    assign samp = sync_q[SYNC_STAGES-1];

    // Debounce filter
    flt_state_t        flt_q, flt_d;
    logic              lvl_q, lvl_d;
    logic [FILT_W-1:0] qcnt_q, qcnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q  <= FLT_STABLE;
            lvl_q  <= 1'b0;
            qcnt_q <= '0;
        end else begin
            flt_q  <= flt_d;
            lvl_q  <= lvl_d;
            qcnt_q <= qcnt_d;
        end
    end

    always_comb begin
        flt_d  = flt_q;
        lvl_d  = lvl_q;
        qcnt_d = qcnt_q;
        unique case (flt_q)
            FLT_STABLE: begin
                if (samp != lvl_q) begin
                    if (filt_code == '0) begin
                        lvl_d = samp;
                    end else begin
                        flt_d  = FLT_QUAL;
                        qcnt_d = FILT_W'(1);
                    end
                end
            end
            FLT_QUAL: begin
                if (samp == lvl_q) begin
                    // bounce: old level came back
                    flt_d  = FLT_STABLE;
                    qcnt_d = '0;
                end else if (qcnt_q >= filt_code) begin
                    // accept: N+1 differing samples seen
                    lvl_d  = samp;
                    flt_d  = FLT_STABLE;
                    qcnt_d = '0;
                end else begin
                    qcnt_d = qcnt_q + FILT_W'(1);
                end
            end
            default: begin
                flt_d  = FLT_STABLE;
                qcnt_d = '0;
            end
        endcase
    end

    // Edge select on filtered level transitions
    logic prev_q;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl_q;
        end
    end

    assign rise   = lvl_q & ~prev_q;
    assign fall   = ~lvl_q & prev_q;
    assign edge_o = pol ? fall : rise;

endmodule

// File: rtl/tcs_trig_mux.sv
// Trigger source selection; only the channel-2 source is populated.
module tcs_trig_mux
    import tcs_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             ch2_edge,
    input  logic [1:0]       ch2_dir,
    input  logic [SEL_W-1:0] trig_sel,
    output logic             trig_o
);

    localparam int NSRC = 2 ** SEL_W;

    logic [NSRC-1:0] src;
    logic            ch2_ok;

    assign ch2_ok = ch2_edge & (ch2_dir == DIR_CH2_IN);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == int'(TSEL_CH2)) begin : g_ch2
            assign src[i] = ch2_ok;
        end else begin : g_tie
            assign src[i] = 1'b0;
        end
    end

    assign trig_o = src[trig_sel];

endmodule

// File: rtl/tcs_cnt_ctrl.sv
// Counter source state machine, counter register and sticky trigger flag.
module tcs_cnt_ctrl
    import tcs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [2:0]       slave_mode,
    input  logic             trig,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output cnt_state_t       state_o
);

    cnt_state_t state_q, state_d;
    logic       inc;

    always_comb begin
        if (!cnt_en) begin
            state_d = CNT_HALT;
        end else if (slave_mode == MODE_INTERNAL) begin
            state_d = CNT_INTCLK;
        end else if (slave_mode == MODE_EXT_EDGE) begin
            state_d = CNT_EXTCLK;
        end else begin
            state_d = CNT_HALT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        inc = 1'b0;
        unique case (state_q)
            CNT_HALT:   inc = 1'b0;
            CNT_INTCLK: inc = 1'b1;
            CNT_EXTCLK: inc = trig;
            default:    inc = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (inc) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

    // set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (trig) begin
            flag_o <= 1'b1;
        end else if (flag_clr) begin
            flag_o <= 1'b0;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/trig_count_slave.sv
module trig_count_slave
    import tcs_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int FILT_W      = 4,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [2:0]        slave_mode,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic [1:0]        ch2_dir,
    input  logic [FILT_W-1:0] filt_code,
    input  logic              ch2_pol,
    input  logic              ch2_pin,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              trig_flag
);

    logic       ch2_edge;
    logic       trig_hit;
    cnt_state_t cnt_state;

    tcs_in_cond #(
        .FILT_W      (FILT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ch2_pin),
        .filt_code (filt_code),
        .pol       (ch2_pol),
        .edge_o    (ch2_edge)
    );

    tcs_trig_mux #(
        .SEL_W (SEL_W)
    ) u_mux (
        .ch2_edge (ch2_edge),
        .ch2_dir  (ch2_dir),
        .trig_sel (trig_sel),
        .trig_o   (trig_hit)
    );

    tcs_cnt_ctrl #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .slave_mode (slave_mode),
        .trig       (trig_hit),
        .flag_clr   (flag_clr),
        .cnt_o      (cnt_val),
        .flag_o     (trig_flag),
        .state_o    (cnt_state)
    );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
    import tcs_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] trig_sel,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cnt_val,
    input logic             trig_flag,
    input cnt_state_t       cnt_state,
    input logic             trig_hit
);

    // R6
    halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_state == CNT_HALT) |=> $stable(cnt_val));

    // R7
    int_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_state == CNT_INTCLK) |=> (cnt_val == $past(cnt_val) + CNT_W'(1)));

    // R11
    ext_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_state == CNT_EXTCLK) |=>
            ((cnt_val == $past(cnt_val)) || (cnt_val == $past(cnt_val) + CNT_W'(1))));

    // R2
    ext_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_state == CNT_EXTCLK && trig_hit) |=> (cnt_val == $past(cnt_val) + CNT_W'(1)));

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> trig_flag);

    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !trig_hit) |=> !trig_flag);

    // R8
    no_foreign_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel != SEL_W'(TSEL_CH2)) |-> !trig_hit);

endmodule

bind trig_count_slave tcs_checker #(
    .CNT_W (CNT_W),
    .SEL_W (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_sel  (trig_sel),
    .flag_clr  (flag_clr),
    .cnt_val   (cnt_val),
    .trig_flag (trig_flag),
    .cnt_state (cnt_state),
    .trig_hit  (trig_hit)
);

// File: tb/tb_trig_count_slave.sv
`timescale 1ns/1ps
module tb_trig_count_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b1;
    logic [2:0]  slave_mode = 3'b111;
    logic [2:0]  trig_sel = 3'b110;
    logic [1:0]  ch2_dir = 2'b01;
    logic [3:0]  filt_code = 4'd0;
    logic        ch2_pol = 1'b0;
    logic        ch2_pin = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] cnt_val;
    logic        trig_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    trig_count_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .slave_mode (slave_mode),
        .trig_sel   (trig_sel),
        .ch2_dir    (ch2_dir),
        .filt_code  (filt_code),
        .ch2_pol    (ch2_pol),
        .ch2_pin    (ch2_pin),
        .flag_clr   (flag_clr),
        .cnt_val    (cnt_val),
        .trig_flag  (trig_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pin_pulse(input int len);
        ch2_pin = 1'b1;
        wait_cyc(len);
        ch2_pin = 1'b0;
        wait_cyc(20);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        wait_cyc(1);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check(cnt_val == 16'd0, "R1 count", cnt_val, 0);
        check(trig_flag == 1'b0, "R1 flag", trig_flag, 0);
    endtask

    task automatic t_latency(input int n);
        logic [15:0] base;
        filt_code = 4'(n);
        wait_cyc(2);
        clear_flag();
        base = cnt_val;
        ch2_pin = 1'b1;
        @(posedge clk);
        repeat (2 + n) @(posedge clk);
        @(negedge clk);
        check(cnt_val == base, "R5 early", cnt_val, base);
        check(trig_flag == 1'b0, "R5 flag early", trig_flag, 0);
        @(posedge clk);
        @(negedge clk);
        check(cnt_val == 16'(base + 1), "R5 R2 count", cnt_val, 16'(base + 1));
        check(trig_flag == 1'b1, "R10 flag set", trig_flag, 1);
        ch2_pin = 1'b0;
        wait_cyc(20);
        check(cnt_val == 16'(base + 1), "R2 fall ignored", cnt_val, 16'(base + 1));
        filt_code = 4'd0;
    endtask

    task automatic t_filter();
        logic [15:0] base;
        filt_code = 4'd0;
        base = cnt_val;
        pin_pulse(1);
        check(cnt_val == 16'(base + 1), "R4 code0 short", cnt_val, 16'(base + 1));
        filt_code = 4'd3;
        base = cnt_val;
        pin_pulse(3);
        check(cnt_val == base, "R4 reject", cnt_val, base);
        pin_pulse(4);
        check(cnt_val == 16'(base + 1), "R4 accept", cnt_val, 16'(base + 1));
        filt_code = 4'd0;
    endtask

    task automatic t_polarity();
        logic [15:0] base;
        ch2_pol = 1'b1;
        wait_cyc(2);
        base = cnt_val;
        ch2_pin = 1'b1;
        wait_cyc(15);
        check(cnt_val == base, "R3 rise ignored", cnt_val, base);
        ch2_pin = 1'b0;
        wait_cyc(15);
        check(cnt_val == 16'(base + 1), "R3 fall counts", cnt_val, 16'(base + 1));
        ch2_pol = 1'b0;
        wait_cyc(2);
    endtask

    task automatic t_level_once();
        logic [15:0] base;
        base = cnt_val;
        ch2_pin = 1'b1;
        wait_cyc(40);
        check(cnt_val == 16'(base + 1), "R11 level once", cnt_val, 16'(base + 1));
        ch2_pin = 1'b0;
        wait_cyc(20);
    endtask

    task automatic t_flag();
        clear_flag();
        check(trig_flag == 1'b0, "R10 clear", trig_flag, 0);
        ch2_pin = 1'b1;
        @(posedge clk);
        repeat (2) @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b0;
        check(trig_flag == 1'b1, "R10 set wins", trig_flag, 1);
        ch2_pin = 1'b0;
        wait_cyc(20);
    endtask

    task automatic t_sel();
        logic [15:0] base;
        clear_flag();
        trig_sel = 3'b100;
        base = cnt_val;
        pin_pulse(5);
        check(cnt_val == base, "R8 count", cnt_val, base);
        check(trig_flag == 1'b0, "R8 flag", trig_flag, 0);
        trig_sel = 3'b110;
    endtask

    task automatic t_dir();
        logic [15:0] base;
        clear_flag();
        ch2_dir = 2'b10;
        base = cnt_val;
        pin_pulse(5);
        check(cnt_val == base, "R9 count", cnt_val, base);
        check(trig_flag == 1'b0, "R9 flag", trig_flag, 0);
        ch2_dir = 2'b01;
    endtask

    task automatic t_enable_ext();
        logic [15:0] base;
        cnt_en = 1'b0;
        wait_cyc(2);
        base = cnt_val;
        pin_pulse(5);
        check(cnt_val == base, "R6 ext off", cnt_val, base);
        cnt_en = 1'b1;
        wait_cyc(2);
    endtask

    task automatic t_internal();
        logic [15:0] a;
        slave_mode = 3'b000;
        wait_cyc(3);
        a = cnt_val;
        wait_cyc(5);
        check(cnt_val == 16'(a + 5), "R7 int step", cnt_val, 16'(a + 5));
        cnt_en = 1'b0;
        wait_cyc(2);
        a = cnt_val;
        wait_cyc(5);
        check(cnt_val == a, "R6 int off", cnt_val, a);
        cnt_en = 1'b1;
        slave_mode = 3'b111;
        wait_cyc(2);
    endtask

    task automatic t_other_mode();
        logic [15:0] a;
        slave_mode = 3'b101;
        wait_cyc(2);
        a = cnt_val;
        pin_pulse(5);
        check(cnt_val == a, "R12 halt", cnt_val, a);
        slave_mode = 3'b111;
        wait_cyc(2);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_latency(0);
        t_latency(2);
        t_filter();
        t_polarity();
        t_level_once();
        t_flag();
        t_sel();
        t_dir();
        t_enable_ext();
        t_internal();
        t_other_mode();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule